// File: doc/BRIEF.md
# Multi-Mode Reload Timer Channel

This block is a single 16-bit counter channel that can run in one of three ways, chosen by a 2-bit mode input. In timer mode it counts down, driven by one of four internal clock enables. When it passes zero it reloads from a reload register and emits an underflow pulse and an interrupt pulse. In event mode it counts down in the same way, but each count comes from a qualified edge on an external pin or from the underflow pulse of a neighbouring channel. In measurement mode it counts up on the selected internal clock. At each measured edge of the external pin it copies the count into the reload register, clears the counter and pulses the interrupt. It can measure either a full period or a pulse width.

Six such channels form two rings of three for cascading. The channel's index parameter fixes which bit of a 6-bit cascade bus it listens to. Software reaches the reload register through separate low and high byte-lane write strobes. The counter and the reload register are both visible on read ports.

Top module: `rtm_channel`

## Requirements
- R1: After reset the counter, the reload register, `uflow_o`, `irq_o` and `ovf_flag_o` are all zero.
- R2: `wr_lo_i` writes `wdata_i[7:0]` into reload bits 7:0, and `wr_hi_i` writes `wdata_i[15:8]` into reload bits 15:8. In modes 00 and 01 with `start_i` low, the counter takes the newly merged reload value on the same edge. With `start_i` high, a write changes only the reload register.
- R3: In mode 00 with `start_i` high, each tick decrements the counter. A tick at count 0 instead loads the old reload value and asserts `uflow_o` and `irq_o` for one cycle after that edge. The repeat period is therefore reload+1 ticks. `clksel_i` selects the tick: 00 is `ce_f1_i`, 01 is `ce_f8_i`, 10 is the divided clock and 11 is `ce_fc32_i`.
- R4: The divided clock fires on an `ce_f1_i` pulse when a free-running divider count is at least L, and the divider then restarts at 0. Otherwise each `ce_f1_i` pulse increments the divider. L is 0 when `div_n_i`=0 (no division) and 2n-1 otherwise, which divides by 2n.
- R5: With `start_i` low and no write, the counter holds and no underflow or interrupt occurs.
- R6: In mode 01 with `clksel_i[1]`=0, the tick is an edge on `ext_in_i`: rising when `pol_i`=0 and falling when `pol_i`=1. The edge is taken against the value sampled on the previous clock.
- R7: In mode 01 with `clksel_i[1]`=1, the tick is one bit of `casc_uflow_i`, chosen by ring mapping. Channel i listens to channel i-1, except that channels 0 and 3 listen to 2 and 5. The default index 1 uses bit 0, and all other bits are ignored.
- R8: In mode 10 with `meas_width_i`=0, ticks increment the counter, wrapping from FFFF to 0. The measured edge is the polarity edge of R6. At that edge the counter value goes to the reload register, the counter clears, `irq_o` pulses and no increment happens.
- R9: In mode 10 with `meas_width_i`=1, both rising and falling edges are measured edges, whatever `pol_i` is.
- R10: A counter wrap in mode 10 sets a pending bit. At each measured edge `ovf_flag_o` takes the pending bit, and the pending bit clears. In mode 10, writes change only the reload register.
- R11: In mode 11 the counter holds, and writes change only the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Counting enable |
| mode_i | input | 2 | 00 timer, 01 event, 10 measure, 11 idle |
| clksel_i | input | 2 | Clock select; bit 1 picks the event source |
| div_n_i | input | 4 | Divider setting n |
| pol_i | input | 1 | 0 rising, 1 falling edge |
| meas_width_i | input | 1 | 1 selects width measurement |
| ce_f1_i | input | 1 | Base clock enable |
| ce_f8_i | input | 1 | Divide-by-8 clock enable |
| ce_fc32_i | input | 1 | Low-speed clock enable |
| ext_in_i | input | 1 | External input pin |
| casc_uflow_i | input | 6 | Underflow pulses of all channels |
| wr_lo_i | input | 1 | Low byte write strobe |
| wr_hi_i | input | 1 | High byte write strobe |
| wdata_i | input | 16 | Write data, both lanes |
| count_o | output | 16 | Counter value |
| reload_o | output | 16 | Reload / capture register |
| uflow_o | output | 1 | Underflow pulse |
| irq_o | output | 1 | Interrupt request pulse |
| ovf_flag_o | output | 1 | Overflow status of the last capture |

## Verification
The bench targets the reload taken on the zero-count tick, so that an off-by-one period would show as a wrong underflow count over a fixed window. It also checks a write while stopped: a design that failed to load the counter would start with a stale first period. It toggles the cascade bits that do not belong to this channel, which exposes a wrong ring index as a moving counter. Measurement runs check that the measured edge clears the counter rather than adding to it, that width mode responds to both edges, and that a full 65536-tick wrap reports overflow only for the capture that follows it.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_MEAS  = 2'b10,
    MODE_IDLE  = 2'b11
  } rtm_mode_e;

  // Divider terminal count: n=0 passes every base tick, n>0 divides by 2n.
  function automatic int unsigned div_limit(input int unsigned n);
    return (n == 0) ? 0 : (2 * n - 1);
  endfunction

  // Cascade ring: groups of three, first of each group takes the last.
  function automatic int unsigned casc_src(input int unsigned idx);
    int unsigned base;
    base = (idx / 3) * 3;
    return (idx == base) ? base + 2 : idx - 1;
  endfunction

endpackage

// File: rtl/rtm_tick_gen.sv
module rtm_tick_gen
  import rtm_pkg::*;
#(
  parameter int DIVW   = 4,
  parameter int NUM_CH = 6,
  parameter int CH_IDX = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        clksel_i,
  input  logic [DIVW-1:0]   div_n_i,
  input  logic              pol_i,
  input  logic              meas_width_i,
  input  logic              ce_f1_i,
  input  logic              ce_f8_i,
  input  logic              ce_fc32_i,
  input  logic              ext_in_i,
  input  logic [NUM_CH-1:0] casc_uflow_i,
  output logic              tick_o,
  output logic              meas_edge_o
);

  localparam int SRC = int'(casc_src(CH_IDX));
  localparam int DCW = DIVW + 1;

  logic [DCW-1:0] div_cnt_q;
  logic [DCW-1:0] div_lim;
  logic           div_tick;
  logic           ext_q;
  logic           ext_rise, ext_fall, pol_edge;
  logic           clk_tick, evt_tick;

  assign div_lim  = DCW'(div_limit(int'(div_n_i)));
  assign div_tick = ce_f1_i && (div_cnt_q >= div_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      ext_q     <= 1'b0;
    end else begin
      ext_q <= ext_in_i;
      if (ce_f1_i) div_cnt_q <= div_tick ? '0 : div_cnt_q + 1'b1;
    end
  end

  assign ext_rise = ext_in_i && !ext_q;
  assign ext_fall = !ext_in_i && ext_q;
  assign pol_edge = pol_i ? ext_fall : ext_rise;

  always_comb begin
    unique case (clksel_i)
      2'b00:   clk_tick = ce_f1_i;
      2'b01:   clk_tick = ce_f8_i;
      2'b10:   clk_tick = div_tick;
      default: clk_tick = ce_fc32_i;
    endcase
  end

  assign evt_tick = clksel_i[1] ? casc_uflow_i[SRC] : pol_edge;

  assign tick_o      = (rtm_mode_e'(mode_i) == MODE_EVENT) ? evt_tick : clk_tick;
  assign meas_edge_o = meas_width_i ? (ext_rise || ext_fall) : pol_edge;

  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_tick && div_n_i != '0) |=> (!div_tick || div_n_i == '0)); // R4

endmodule

// File: rtl/rtm_count_core.sv
module rtm_count_core
  import rtm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic         tick_i,
  input  logic         meas_edge_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         uflow_o,
  output logic         irq_o,
  output logic         ovf_flag_o
);

  localparam int            LO_W = W / 2;
  localparam logic [W-1:0]  ALL1 = '1;

  logic [W-1:0] cnt_q, cnt_nxt, reload_q, reload_wr, reload_nxt;
  logic         uflow_q, irq_q, pend_q, flag_q;
  logic         wr_any, is_down, is_meas;
  logic         underflow_now, meas_cap, meas_wrap;

  function automatic logic [W-1:0] merge_lanes(input logic [W-1:0] cur,
                                               input logic [W-1:0] wd,
                                               input logic lo, input logic hi);
    logic [W-1:0] r;
    r = cur;
    if (lo) r[LO_W-1:0] = wd[LO_W-1:0];
    if (hi) r[W-1:LO_W] = wd[W-1:LO_W];
    return r;
  endfunction

  function automatic logic [W-1:0] down_step(input logic [W-1:0] c,
                                             input logic [W-1:0] rl);
    return (c == '0) ? rl : c - 1'b1;
  endfunction

  assign wr_any    = wr_lo_i || wr_hi_i;
  assign is_down   = (rtm_mode_e'(mode_i) == MODE_TIMER) || (rtm_mode_e'(mode_i) == MODE_EVENT);
  assign is_meas   = (rtm_mode_e'(mode_i) == MODE_MEAS);
  assign reload_wr = merge_lanes(reload_q, wdata_i, wr_lo_i, wr_hi_i);

  assign underflow_now = is_down && start_i && tick_i && (cnt_q == '0);
  assign meas_cap      = is_meas && start_i && meas_edge_i;
  assign meas_wrap     = is_meas && start_i && tick_i && !meas_edge_i && (cnt_q == ALL1);

  always_comb begin
    cnt_nxt = cnt_q;
    if (is_down) begin
      if (start_i && tick_i)     cnt_nxt = down_step(cnt_q, reload_q);
      else if (!start_i && wr_any) cnt_nxt = reload_wr;
    end else if (is_meas && start_i) begin
      if (meas_cap)    cnt_nxt = '0;
      else if (tick_i) cnt_nxt = cnt_q + 1'b1;
    end
  end

  assign reload_nxt = meas_cap ? cnt_q : reload_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      uflow_q  <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      reload_q <= reload_nxt;
      uflow_q  <= underflow_now;
      irq_q    <= underflow_now || meas_cap;
      pend_q   <= meas_cap ? 1'b0 : (pend_q || meas_wrap);
      if (meas_cap) flag_q <= pend_q;
    end
  end

  assign count_o    = cnt_q;
  assign reload_o   = reload_q;
  assign uflow_o    = uflow_q;
  assign irq_o      = irq_q;
  assign ovf_flag_o = flag_q;

  AST_RELOAD_ON_UFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_q |-> (cnt_q == $past(reload_q))); // R3

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wr_any) |=> $stable(cnt_q)); // R5

  AST_NO_UFLOW_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !uflow_q); // R5

  AST_MEAS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_meas && start_i && meas_edge_i) |=> (cnt_q == '0 && irq_q)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtm_mode_e'(mode_i) == MODE_IDLE) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/rtm_channel.sv
module rtm_channel
  import rtm_pkg::*;
#(
  parameter int W      = 16,
  parameter int DIVW   = 4,
  parameter int NUM_CH = 6,
  parameter int CH_IDX = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        clksel_i,
  input  logic [DIVW-1:0]   div_n_i,
  input  logic              pol_i,
  input  logic              meas_width_i,
  input  logic              ce_f1_i,
  input  logic              ce_f8_i,
  input  logic              ce_fc32_i,
  input  logic              ext_in_i,
  input  logic [NUM_CH-1:0] casc_uflow_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      reload_o,
  output logic              uflow_o,
  output logic              irq_o,
  output logic              ovf_flag_o
);

  logic tick;
  logic meas_edge;

  rtm_tick_gen #(.DIVW(DIVW), .NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .clksel_i(clksel_i),
    .div_n_i(div_n_i), .pol_i(pol_i), .meas_width_i(meas_width_i),
    .ce_f1_i(ce_f1_i), .ce_f8_i(ce_f8_i), .ce_fc32_i(ce_fc32_i),
    .ext_in_i(ext_in_i), .casc_uflow_i(casc_uflow_i),
    .tick_o(tick), .meas_edge_o(meas_edge)
  );

  rtm_count_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .tick_i(tick), .meas_edge_i(meas_edge),
    .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wdata_i(wdata_i),
    .count_o(count_o), .reload_o(reload_o), .uflow_o(uflow_o),
    .irq_o(irq_o), .ovf_flag_o(ovf_flag_o)
  );

endmodule

// File: tb/rtm_channel_tb.sv
module rtm_channel_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  clksel = 2'b00;
  logic [3:0]  div_n = 4'd0;
  logic        pol = 1'b0;
  logic        meas_width = 1'b0;
  logic        ce_f1 = 1'b0, ce_f8 = 1'b0, ce_fc32 = 1'b0;
  logic        ext_in = 1'b0;
  logic [5:0]  casc = 6'd0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] count_o, reload_o;
  logic        uflow_o, irq_o, ovf_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit f1_on = 1'b1;
  bit done = 1'b0;
  string cur_req = "R1";
  int uf_seen = 0;

  // reference model state
  int m_cnt = 0, m_rel = 0, m_div = 0;
  bit m_uf = 0, m_irq = 0, m_pend = 0, m_ovf = 0, m_ext = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtm_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .clksel_i(clksel),
    .div_n_i(div_n), .pol_i(pol), .meas_width_i(meas_width),
    .ce_f1_i(ce_f1), .ce_f8_i(ce_f8), .ce_fc32_i(ce_fc32), .ext_in_i(ext_in),
    .casc_uflow_i(casc), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .count_o(count_o), .reload_o(reload_o), .uflow_o(uflow_o), .irq_o(irq_o),
    .ovf_flag_o(ovf_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_div = 0; m_uf = 0; m_irq = 0;
      m_pend = 0; m_ovf = 0; m_ext = 0;
    end else begin
      bit rise, fall, pe, dt, tk, edge_m;
      int lim, newrel;
      rise = ext_in && !m_ext;
      fall = !ext_in && m_ext;
      pe   = pol ? fall : rise;
      lim  = (div_n == 0) ? 0 : 2 * div_n - 1;
      dt   = ce_f1 && (m_div >= lim);
      if (ce_f1) m_div = dt ? 0 : m_div + 1;
      case (clksel)
        2'b00: tk = ce_f1;
        2'b01: tk = ce_f8;
        2'b10: tk = dt;
        default: tk = ce_fc32;
      endcase
      if (mode == 2'b01) tk = clksel[1] ? casc[0] : pe;
      newrel = m_rel;
      if (wr_lo) newrel = (newrel & 16'hFF00) | (wdata & 16'h00FF);
      if (wr_hi) newrel = (newrel & 16'h00FF) | (wdata & 16'hFF00);
      m_uf = 0; m_irq = 0;
      if (mode == 2'b00 || mode == 2'b01) begin
        if (start && tk) begin
          if (m_cnt == 0) begin m_cnt = m_rel; m_uf = 1; m_irq = 1; end
          else m_cnt = m_cnt - 1;
        end else if (!start && (wr_lo || wr_hi)) m_cnt = newrel;
        m_rel = newrel;
      end else if (mode == 2'b10) begin
        edge_m = meas_width ? (rise || fall) : pe;
        if (start && edge_m) begin
          m_rel = m_cnt; m_cnt = 0; m_irq = 1; m_ovf = m_pend; m_pend = 0;
        end else begin
          m_rel = newrel;
          if (start && tk) begin
            if (m_cnt == 65535) m_pend = 1;
            m_cnt = (m_cnt + 1) % 65536;
          end
        end
      end else begin
        m_rel = newrel;
      end
      m_ext = ext_in;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then set clock enables
  task automatic step();
    @(negedge clk);
    checks++;
    if (count_o != m_cnt[15:0] || reload_o != m_rel[15:0] || uflow_o != m_uf ||
        irq_o != m_irq || ovf_o != m_ovf) begin
      failures++;
      $display("FAIL %s cycle %0d actual cnt=%0h rel=%0h uf=%0b irq=%0b ovf=%0b expected cnt=%0h rel=%0h uf=%0b irq=%0b ovf=%0b",
               cur_req, cyc, count_o, reload_o, uflow_o, irq_o, ovf_o,
               m_cnt, m_rel, m_uf, m_irq, m_ovf);
    end
    if (uflow_o) uf_seen++;
    cyc++;
    ce_f1   = f1_on;
    ce_f8   = (cyc % 8 == 0);
    ce_fc32 = (cyc % 40 == 0);
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic bus_wr(input bit lo, input bit hi, input logic [15:0] d);
    wr_lo = lo; wr_hi = hi; wdata = d;
    step();
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    steps(2);
    cur_req = "R1";
    chk("R1", count_o, 0, "count after reset");
    chk("R1", {reload_o, uflow_o, irq_o, ovf_o}, 0, "reload/flags after reset");
    rst_n = 1'b1;
    steps(2);

    // R2: stopped write loads counter, lanes separate
    cur_req = "R2";
    bus_wr(1, 0, 16'hAB34);
    chk("R2", reload_o, 16'h0034, "low lane write");
    bus_wr(0, 1, 16'h12CD);
    chk("R2", count_o, 16'h1234, "counter loaded while stopped");
    bus_wr(1, 1, 16'h0003);

    // R3: timer on f1, reload 3 gives period 4
    cur_req = "R3";
    start = 1'b1;
    uf_seen = 0;
    steps(20);
    chk("R3", uf_seen, 5, "underflows in 20 f1 ticks with reload 3");
    clksel = 2'b01; steps(40);
    clksel = 2'b11; steps(90);

    // R4: divided clock, n=3 -> every 6 f1 ticks
    cur_req = "R4";
    bus_wr(1, 1, 16'h0000);
    clksel = 2'b10; div_n = 4'd3;
    steps(12);
    uf_seen = 0;
    steps(60);
    chk("R4", uf_seen, 10, "divided ticks over 60 cycles n=3");
    div_n = 4'd0; steps(10);

    // R2: write while running keeps counter
    cur_req = "R2";
    f1_on = 1'b0; clksel = 2'b00;
    bus_wr(1, 1, 16'h0050);
    start = 1'b0; bus_wr(1, 1, 16'h0050); start = 1'b1;
    bus_wr(1, 0, 16'h00AA);
    chk("R2", count_o, 16'h0050, "running write leaves counter");
    chk("R2", reload_o, 16'h00AA, "running write sets reload");

    // R5: stop holds
    cur_req = "R5";
    f1_on = 1'b1; steps(5);
    start = 1'b0; c0 = count_o;
    uf_seen = 0;
    steps(10);
    chk("R5", count_o, c0, "counter held while stopped");
    chk("R5", uf_seen, 0, "no underflow while stopped");

    // R6: event on pin edges
    cur_req = "R6";
    bus_wr(1, 1, 16'h0010);
    mode = 2'b01; clksel = 2'b00; pol = 1'b0; start = 1'b1;
    for (int k = 0; k < 3; k++) begin ext_in = 1'b1; steps(2); ext_in = 1'b0; steps(2); end
    chk("R6", count_o, 16'h000D, "three rising edges");
    pol = 1'b1;
    for (int k = 0; k < 2; k++) begin ext_in = 1'b1; steps(2); ext_in = 1'b0; steps(2); end
    chk("R6", count_o, 16'h000B, "two falling edges");

    // R7: cascade from bit 0 only
    cur_req = "R7";
    clksel = 2'b10;
    c0 = count_o;
    for (int k = 0; k < 4; k++) begin casc = 6'b111110; step(); casc = 6'd0; step(); end
    chk("R7", count_o, c0, "foreign cascade bits ignored");
    start = 1'b0; bus_wr(1, 1, 16'h0002); start = 1'b1;
    uf_seen = 0;
    for (int k = 0; k < 3; k++) begin casc = 6'b000001; step(); casc = 6'd0; step(); end
    chk("R7", uf_seen, 1, "underflow on third cascade pulse");

    // R11: idle mode holds
    cur_req = "R11";
    mode = 2'b11; c0 = count_o;
    bus_wr(1, 1, 16'h0777);
    steps(10);
    chk("R11", count_o, c0, "idle mode holds counter");

    // R8: period measurement
    cur_req = "R8";
    mode = 2'b10; clksel = 2'b00; pol = 1'b0; meas_width = 1'b0;
    ext_in = 1'b0; steps(2);
    ext_in = 1'b1; step();
    steps(3); ext_in = 1'b0; steps(6);
    ext_in = 1'b1; step();
    chk("R8", reload_o, 9, "period capture");
    chk("R8", count_o, 0, "counter cleared at edge");

    // R9: width measurement
    cur_req = "R9";
    meas_width = 1'b1;
    ext_in = 1'b0; step();
    ext_in = 1'b1; step();
    steps(4);
    ext_in = 1'b0; step();
    chk("R9", reload_o, 4, "width capture on falling edge");

    // R10: overflow across 65536 ticks
    cur_req = "R10";
    ext_in = 1'b1; step();
    steps(65540);
    ext_in = 1'b0; step();
    chk("R10", ovf_o, 1, "overflow flag after wrap");
    steps(5);
    ext_in = 1'b1; step();
    chk("R10", ovf_o, 0, "flag cleared for clean interval");
    chk("R10", reload_o, 5, "capture after clean interval");

    steps(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule